// File: doc/BRIEF.md
# Multichannel Wilkinson Conversion Backend

This block is the digital half of a many-channel single-slope (Wilkinson) converter. On a start request it clears a shared counter and lets it climb by one step per clock, in step with an external ramp. Each channel watches its own end-of-ramp comparator. The first time that comparator is seen high, the channel takes the current counter value. The counter steps in Gray code, so a sample taken during a transition is off by at most one code.

The conversion ends once every channel has taken its value or the counter reaches full scale. A channel that never fired gets the full-scale code. Together with the gain-range bits, hit flags and crossing ID taken at the start, the results leave as one word on a memory write port. The captured Gray codes are turned into plain binary on the way out. The event memory holds a fixed number of words. Once it is full, further start requests are refused until reset.

Top module: `wilkinson_gray_backend`

## Requirements
- R1: After reset `busy`, `wr_en` and `ram_full` are low and `wr_addr` is 0.
- R2: A `conv_start` seen high at a clock edge while idle and not full makes `busy` high from the next cycle. The count is 0 in the first conversion cycle and rises by one per clock.
- R3: A channel whose comparator is first seen high at the edge where the count is c stores c. Later comparator activity for that channel in the same conversion has no effect, and a one-cycle comparator pulse is enough.
- R4: A channel whose comparator has not fired by the edge where the count equals full scale (2^CW-1) stores 2^CW-1.
- R5: The conversion ends at the edge where the last channel latches, or where the count is at full scale if that comes first. `wr_en` is high for exactly the following cycle, and `busy` falls one cycle later.
- R6: The gain bits, hit bits and crossing ID written for an event are the values on `gain_i`, `hit_i` and `bcid_i` at the accepting start edge. Later changes on those inputs are ignored.
- R7: The write word holds these fields, from the least significant bit upward:
  - the binary code of channel i at bits [i*CW +: CW];
  - the gain bits at [NCH*CW +: NCH];
  - the hit bits at [NCH*(CW+1) +: NCH];
  - the crossing ID in the top BCW bits.
- R8: `wr_addr` is 0 for the first event and rises by one per write. After DEPTH writes `ram_full` is high, and start requests produce neither `busy` nor `wr_en` until reset.
- R9: During a conversion, successive counter values differ in exactly one Gray-code bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock (nominally 40 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_start | input | 1 | Request to begin a conversion |
| eor_i | input | NCH | End-of-ramp comparator outputs, one per channel |
| gain_i | input | NCH | Gain-range select per channel (1 = high gain) |
| hit_i | input | NCH | Trigger hit flags per channel |
| bcid_i | input | BCW | Bunch-crossing ID of the event |
| busy | output | 1 | Conversion or write in progress |
| wr_en | output | 1 | Event memory write strobe |
| wr_addr | output | log2(DEPTH) | Event memory write address |
| wr_data | output | NCH*(CW+2)+BCW | Event word (layout in R7) |
| ram_full | output | 1 | Event memory holds DEPTH events |

## Verification
The hardest case to reach is a mix within one conversion. It has early channels, late channels, single-cycle comparator pulses and channels that never fire, all while the end condition flips from "all latched" to "full scale reached". The bench shrinks the counter to 6 bits and gives every channel its own arithmetic threshold. Across the events this sweeps nearly every code, pushes some channels past full scale and drives pulse-only comparators. After each event it checks the end cycle and every field. It then fills the small memory to test start refusal.

// File: rtl/wilkinson_gray_backend.sv
module wilkinson_gray_backend #(
  parameter int NCH   = 36,
  parameter int CW    = 12,
  parameter int DEPTH = 16,
  parameter int BCW   = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int WW = NCH * (CW + 2) + BCW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           conv_start,
  input  logic [NCH-1:0] eor_i,
  input  logic [NCH-1:0] gain_i,
  input  logic [NCH-1:0] hit_i,
  input  logic [BCW-1:0] bcid_i,
  output logic           busy,
  output logic           wr_en,
  output logic [AW-1:0]  wr_addr,
  output logic [WW-1:0]  wr_data,
  output logic           ram_full
);

  typedef enum logic [1:0] {IDLE, RUN, WRITE} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [NCH-1:0]    done;
  logic [NCH*CW-1:0] code_g;
  logic [NCH*CW-1:0] code_b;
  logic [NCH-1:0]    gain_q, hit_q;
  logic [BCW-1:0]    bcid_q;
  logic [AW:0]       fill;

  wire [CW-1:0]  cnt_gray = cnt ^ (cnt >> 1);
  wire           at_top   = &cnt;
  wire [NCH-1:0] fire     = ~done & (eor_i | {NCH{at_top}});
  wire           all_done = &(done | fire);

  function automatic logic [CW-1:0] g2b(input logic [CW-1:0] g);
    logic [CW-1:0] b;
    b[CW-1] = g[CW-1];
    for (int k = CW - 2; k >= 0; k--) b[k] = b[k+1] ^ g[k];
    return b;
  endfunction

  for (genvar i = 0; i < NCH; i++) begin : g_conv
    assign code_b[i*CW +: CW] = g2b(code_g[i*CW +: CW]);
  end

  assign busy     = (st != IDLE);
  assign wr_en    = (st == WRITE);
  assign ram_full = (fill == (AW+1)'(DEPTH));
  assign wr_addr  = fill[AW-1:0];
  assign wr_data  = {bcid_q, hit_q, gain_q, code_b};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      cnt    <= '0;
      done   <= '0;
      code_g <= '0;
      gain_q <= '0;
      hit_q  <= '0;
      bcid_q <= '0;
      fill   <= '0;
    end else begin
      case (st)
        IDLE: if (conv_start && !ram_full) begin
          st     <= RUN;
          cnt    <= '0;
          done   <= '0;
          gain_q <= gain_i;
          hit_q  <= hit_i;
          bcid_q <= bcid_i;
        end
        RUN: begin
          if (!at_top) cnt <= cnt + 1'b1;
          for (int i = 0; i < NCH; i++)
            if (fire[i]) code_g[i*CW +: CW] <= cnt_gray;
          done <= done | fire;
          if (all_done) st <= WRITE;
        end
        WRITE: begin
          st   <= IDLE;
          fill <= fill + 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

endmodule

module wgb_checker #(
  parameter int NCH = 36,
  parameter int CW  = 12,
  parameter int AW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           conv_start,
  input logic           busy,
  input logic           wr_en,
  input logic           ram_full,
  input logic [CW-1:0]  cnt_gray,
  input logic [NCH-1:0] done,
  input logic [NCH*CW-1:0] code_g
);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && conv_start && !ram_full) |=> busy);

  // R5
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!wr_en && !busy));

  // R8
  no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !ram_full);

  // R8
  full_refuses_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_full && !busy) |=> !busy);

  // R9
  gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && cnt_gray != $past(cnt_gray))
      |-> $countones(cnt_gray ^ $past(cnt_gray)) == 1);

  for (genvar i = 0; i < NCH; i++) begin : g_hold
    // R3
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done[i] |=> $stable(code_g[i*CW +: CW]));
  end

endmodule

bind wilkinson_gray_backend wgb_checker #(.NCH(NCH), .CW(CW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .busy(busy),
  .wr_en(wr_en), .ram_full(ram_full), .cnt_gray(cnt_gray),
  .done(done), .code_g(code_g)
);

// File: tb/wilkinson_gray_backend_tb.sv
module wilkinson_gray_backend_tb_top;
  localparam int NCH = 36, CW = 6, DEPTH = 4, BCW = 8;
  localparam int AW = $clog2(DEPTH);
  localparam int WW = NCH * (CW + 2) + BCW;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, conv_start = 0;
  logic [NCH-1:0] eor_i = '0, gain_i = '0, hit_i = '0;
  logic [BCW-1:0] bcid_i = '0;
  logic busy, wr_en, ram_full;
  logic [AW-1:0] wr_addr;
  logic [WW-1:0] wr_data;

  int checks = 0, fails = 0, cycles = 0;
  int thr [NCH];

  wilkinson_gray_backend #(.NCH(NCH), .CW(CW), .DEPTH(DEPTH), .BCW(BCW)) dut_i (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .eor_i(eor_i),
    .gain_i(gain_i), .hit_i(hit_i), .bcid_i(bcid_i), .busy(busy),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ram_full(ram_full));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: got %0d cycles exp fewer than 100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint got, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic run_conv(input int idx, input bit pulse, input logic [NCH-1:0] g,
                          input logic [NCH-1:0] h, input logic [BCW-1:0] b);
    int t, tmax;
    bit seen;
    tmax = 0;
    for (int c = 0; c < NCH; c++) if (thr[c] > tmax) tmax = thr[c];
    if (tmax > MAXC) tmax = MAXC;
    @(negedge clk);
    gain_i = g; hit_i = h; bcid_i = b; conv_start = 1; eor_i = '0;
    @(negedge clk);
    conv_start = 0;
    chk(busy === 1'b1, "R2 busy after start", busy, 1);
    gain_i = ~g; hit_i = ~h; bcid_i = ~b;
    t = 0; seen = 0;
    while (!seen && t < 200) begin
      for (int c = 0; c < NCH; c++)
        eor_i[c] = pulse ? (t == thr[c]) : (t >= thr[c]);
      @(negedge clk);
      if (wr_en) seen = 1; else t++;
    end
    chk(seen && t == tmax, "R5 end cycle", t, tmax);
    chk(wr_addr == AW'(idx), "R8 write address", wr_addr, idx);
    for (int c = 0; c < NCH; c++) begin
      int e;
      e = thr[c] > MAXC ? MAXC : thr[c];
      chk(int'(wr_data[c*CW +: CW]) == e, thr[c] > MAXC ? "R4 saturated code" : "R3 R7 channel code",
          wr_data[c*CW +: CW], e);
    end
    chk(wr_data[NCH*CW +: NCH] == g, "R6 R7 gain field", wr_data[NCH*CW +: NCH], g);
    chk(wr_data[NCH*(CW+1) +: NCH] == h, "R6 R7 hit field", wr_data[NCH*(CW+1) +: NCH], h);
    chk(wr_data[WW-1 -: BCW] == b, "R6 R7 crossing id", wr_data[WW-1 -: BCW], b);
    eor_i = '0;
    @(negedge clk);
    chk(!wr_en && !busy, "R5 single write", {wr_en, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !wr_en && !ram_full && wr_addr == 0, "R1 reset state",
        {busy, wr_en, ram_full, wr_addr}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int c = 0; c < NCH; c++) thr[c] = c;
    run_conv(0, 0, 36'h5A5A5A5A5, 36'h0F0F0F0F0, 8'h5A);

    for (int c = 0; c < NCH; c++) thr[c] = MAXC - c;
    run_conv(1, 0, 36'hFFFF00000, 36'h123456789, 8'hC3);

    for (int c = 0; c < NCH; c++) thr[c] = 40 + c;
    run_conv(2, 0, 36'h000000001, 36'h800000000, 8'h01);

    chk(!ram_full, "R8 not full before last write", ram_full, 0);
    for (int c = 0; c < NCH; c++) thr[c] = (c * 7) % 60;
    run_conv(3, 1, 36'hABCDEF012, 36'hFEDCBA987, 8'hFF);

    chk(ram_full === 1'b1, "R8 full after DEPTH writes", ram_full, 1);
    @(negedge clk);
    conv_start = 1;
    begin
      bit saw;
      saw = 0;
      repeat (10) begin
        @(negedge clk);
        if (busy || wr_en) saw = 1;
      end
      conv_start = 0;
      chk(!saw, "R8 start ignored when full", saw, 0);
    end

    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    chk(!ram_full && wr_addr == 0 && !busy, "R1 reset clears fill",
        {ram_full, wr_addr, busy}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule